// File: doc/BRIEF.md
# Queue Status Flags and Interrupt Selector

This block turns the fill levels of 64 hardware queues into registered status flags and per-queue interrupts. For each queue it receives the current fill level, the capacity, a nearly-empty mark and a nearly-full mark. From these it derives four conditions: empty, nearly empty, nearly full and full. Queues 0 to 31 (the lower group) report all four conditions as a 4-bit field. Queues 32 to 63 (the upper group) report only nearly empty and full, one bit per queue each. The lower group also keeps sticky underflow and overflow bits, which are set by single-cycle pulses from the queue controller.

Each lower queue has a source selector. It picks which of its conditions, or the inverse of one of them, raises that queue's interrupt. Upper queues always use nearly empty. A pending bit is latched when the chosen condition goes from false to true while the queue is enabled. Software clears a pending bit by writing one to it. A single line is high while any enabled queue has a pending bit.

All state is reached through a simple word-addressed register port. Reads are combinational, and writes take effect on the clock edge.

Top module: `qstat_irq`

## Requirements
- R1: Queue q (0..31) has a 4-bit field in word q/8, at bits 4*(q%8)+3..4*(q%8). In that field, bit0 is empty (level == 0), bit1 is nearly empty (level <= nearly-empty mark), bit2 is nearly full (level >= capacity, or capacity minus level <= nearly-full mark), and bit3 is full (level >= capacity). The flags follow the inputs one clock later.
- R2: After reset, words 0..3 read 0x33333333.
- R3: Word 6 bit (q-32) is the nearly-empty flag of upper queue q, and resets to all ones. Word 7 bit (q-32) is its full flag, and resets to zero.
- R4: Words 4 (queues 0..15) and 5 (queues 16..31) hold underflow at bit 2*(q%16) and overflow at bit 2*(q%16)+1. A pulse sets the bit, and the bit stays set until software writes a one to it. Writing a one clears only that bit. These words reset to zero.
- R5: Words 8..11 hold a selector for lower queue q at bits 4*(q%8)+2..4*(q%8) of word 8+q/8. Codes 0, 1, 2 and 3 pick empty, nearly empty, nearly full and full. Codes 4..7 pick the inverse of the same condition. The selector words reset to zero.
- R6: Word 8 bit 3 is a separate control bit that is written only through word 16 bit 0. A write to word 8 leaves it unchanged.
- R7: Enable words 12 and 13 have one bit per queue and reset to zero. Pending words 14 and 15 reset to all ones.
- R8: A pending bit is set two clocks after the input change that makes the queue's selected condition go from false to true, provided the queue is enabled. Upper queues use nearly empty. A disabled queue never sets its pending bit.
- R9: Writing a one to a pending bit clears it. A condition that stays true does not set the bit again.
- R10: irq is the OR of every pending bit that is also enabled. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fill_lvl | input | 64*LVL_W | Fill level per queue, queue q at slice q |
| fill_cap | input | 64*LVL_W | Capacity per queue |
| ne_mark | input | 64*LVL_W | Nearly-empty mark per queue |
| nf_mark | input | 64*LVL_W | Nearly-full mark (free entries) per queue |
| uf_pulse | input | 32 | Underflow pulse, lower queues |
| of_pulse | input | 32 | Overflow pulse, lower queues |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench covers levels at the exact marks, at capacity and above capacity, where an off-by-one comparison would leave nearly empty or nearly full clear or set on the wrong level. It checks that pending bits latch on edges only. A level-sensitive design would set the bit again right after software clears it, and would also set it for a queue that is disabled. It checks inverted selection: a design that ignored the top code bit would not fire when a queue leaves empty. It also checks that writing the queue-0 selector keeps the separate control bit, and that clearing one underflow bit leaves the others sticky.

// File: rtl/qstat_irq.sv
module qstat_irq #(
  parameter int LVL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [64*LVL_W-1:0] fill_lvl,
  input  logic [64*LVL_W-1:0] fill_cap,
  input  logic [64*LVL_W-1:0] ne_mark,
  input  logic [64*LVL_W-1:0] nf_mark,
  input  logic [31:0]        uf_pulse,
  input  logic [31:0]        of_pulse,
  input  logic               reg_we,
  input  logic [4:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  localparam int NQ  = 64;
  localparam int NLO = NQ / 2;

  logic [NQ-1:0] c_e, c_ne, c_nf, c_f;
  logic [NQ-1:0] f_e, f_ne, f_nf, f_f;
  logic [NQ-1:0] en, ist, prev, cond;
  logic [2*NLO-1:0] uo, uo_set, uo_clr;
  logic [31:0] sel_r [4];
  logic [4*NLO-1:0] lo_stat;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [LVL_W-1:0] lv, cp;
    assign lv = fill_lvl[q*LVL_W +: LVL_W];
    assign cp = fill_cap[q*LVL_W +: LVL_W];
    assign c_e[q]  = (lv == '0);
    assign c_ne[q] = (lv <= ne_mark[q*LVL_W +: LVL_W]);
    assign c_f[q]  = (lv >= cp);
    assign c_nf[q] = c_f[q] || ((cp - lv) <= nf_mark[q*LVL_W +: LVL_W]);
    if (q < NLO) begin : g_lo
      logic [2:0] code;
      logic       base;
      assign code = sel_r[q/8][(q%8)*4 +: 3];
      always_comb
        case (code[1:0])
          2'd0: base = f_e[q];
          2'd1: base = f_ne[q];
          2'd2: base = f_nf[q];
          default: base = f_f[q];
        endcase
      assign cond[q] = base ^ code[2];
      assign lo_stat[q*4 +: 4] = {f_f[q], f_nf[q], f_ne[q], f_e[q]};
      assign uo_set[2*q]   = uf_pulse[q];
      assign uo_set[2*q+1] = of_pulse[q];
    end else begin : g_hi
      assign cond[q] = f_ne[q];
    end
  end

  assign uo_clr = {(reg_we && reg_addr == 5'd5) ? reg_wdata : 32'd0,
                   (reg_we && reg_addr == 5'd4) ? reg_wdata : 32'd0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_e  <= '1;
      f_ne <= '1;
      f_nf <= '0;
      f_f  <= '0;
      uo   <= '0;
      prev <= '0;
    end else begin
      f_e  <= c_e;
      f_ne <= c_ne;
      f_nf <= c_nf;
      f_f  <= c_f;
      uo   <= (uo & ~uo_clr) | uo_set;
      prev <= cond;
    end

  logic [NQ-1:0] ist_clr;
  assign ist_clr = {(reg_we && reg_addr == 5'd15) ? reg_wdata : 32'd0,
                    (reg_we && reg_addr == 5'd14) ? reg_wdata : 32'd0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en  <= '0;
      ist <= '1;
      for (int i = 0; i < 4; i++) sel_r[i] <= '0;
    end else begin
      ist <= (ist & ~ist_clr) | (cond & ~prev & en);
      if (reg_we) begin
        case (reg_addr)
          5'd8:  sel_r[0] <= {reg_wdata[31:4], sel_r[0][3], reg_wdata[2:0]};
          5'd9:  sel_r[1] <= reg_wdata;
          5'd10: sel_r[2] <= reg_wdata;
          5'd11: sel_r[3] <= reg_wdata;
          5'd12: en[31:0] <= reg_wdata;
          5'd13: en[63:32] <= reg_wdata;
          5'd16: sel_r[0][3] <= reg_wdata[0];
          default: ;
        endcase
      end
    end

  assign irq = |(ist & en);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      5'd0:  reg_rdata = lo_stat[31:0];
      5'd1:  reg_rdata = lo_stat[63:32];
      5'd2:  reg_rdata = lo_stat[95:64];
      5'd3:  reg_rdata = lo_stat[127:96];
      5'd4:  reg_rdata = uo[31:0];
      5'd5:  reg_rdata = uo[63:32];
      5'd6:  reg_rdata = f_ne[63:32];
      5'd7:  reg_rdata = f_f[63:32];
      5'd8:  reg_rdata = sel_r[0];
      5'd9:  reg_rdata = sel_r[1];
      5'd10: reg_rdata = sel_r[2];
      5'd11: reg_rdata = sel_r[3];
      5'd12: reg_rdata = en[31:0];
      5'd13: reg_rdata = en[63:32];
      5'd14: reg_rdata = ist[31:0];
      5'd15: reg_rdata = ist[63:32];
      5'd16: reg_rdata = {31'd0, sel_r[0][3]};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module qstat_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [63:0] en,
  input logic [63:0] ist,
  input logic [63:0] uo,
  input logic [31:0] uf_pulse,
  input logic [31:0] ctl_word,
  input logic        reg_we,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata
);
  // R4
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_pulse[0] |=> uo[0]);
  // R4
  uf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uo[0]) |-> $past(reg_we && reg_addr == 5'd4 && reg_wdata[0]));
  // R6
  ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'd8) |=> $stable(ctl_word[3]));
  // R8
  set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist & ~$past(ist) & ~$past(en)) == 64'd0));
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 64'd0) |-> !irq);
endmodule

bind qstat_irq qstat_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .en(en), .ist(ist), .uo(uo),
  .uf_pulse(uf_pulse), .ctl_word(sel_r[0]), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_qstat_irq.sv
`timescale 1ns/1ps
module sim_qstat_irq;
  localparam int LW = 8;
  logic clk = 0, rst_n = 0;
  logic [64*LW-1:0] fill_lvl, fill_cap, ne_mark, nf_mark;
  logic [31:0] uf_pulse = 0, of_pulse = 0, reg_wdata = 0, reg_rdata;
  logic reg_we = 0, irq;
  logic [4:0] reg_addr = 0;
  logic [LW-1:0] lvl_a [64];
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  always_comb
    for (int q = 0; q < 64; q++) begin
      fill_lvl[q*LW +: LW] = lvl_a[q];
      fill_cap[q*LW +: LW] = 8'd64;
      ne_mark[q*LW +: LW]  = 8'd4;
      nf_mark[q*LW +: LW]  = 8'd4;
    end

  qstat_irq #(.LVL_W(LW)) u0 (.*);

  // {queue, level, expected nibble}
  localparam logic [17:0] VEC [8] = '{
    {6'd0, 8'd0, 4'h3}, {6'd1, 8'd2, 4'h2}, {6'd9, 8'd4, 4'h2},
    {6'd10, 8'd5, 4'h0}, {6'd18, 8'd60, 4'h4}, {6'd19, 8'd61, 4'h4},
    {6'd27, 8'd64, 4'hC}, {6'd31, 8'd70, 4'hC}};

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rdw(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wrw(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int q = 0; q < 64; q++) lvl_a[q] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int w = 0; w < 4; w++) begin rdw(5'(w), rd); chk(rd, 32'h33333333, "R2 lower status reset"); end
    rdw(5'd4, rd); chk(rd, 0, "R4 uo reset");
    rdw(5'd6, rd); chk(rd, 32'hFFFFFFFF, "R3 upper NE reset");
    rdw(5'd7, rd); chk(rd, 0, "R3 upper F reset");
    rdw(5'd8, rd); chk(rd, 0, "R5 selector reset");
    rdw(5'd12, rd); chk(rd, 0, "R7 enable reset");
    rdw(5'd15, rd); chk(rd, 32'hFFFFFFFF, "R7 pending reset");
    chk({31'd0, irq}, 0, "R10 irq after reset");

    for (int i = 0; i < 8; i++) begin
      lvl_a[VEC[i][17:12]] = VEC[i][11:4];
      @(negedge clk);
      rdw(5'(VEC[i][17:12] / 8), rd);
      chk({28'd0, rd[(VEC[i][17:12] % 8) * 4 +: 4]}, {28'd0, VEC[i][3:0]}, "R1 flag nibble");
    end

    lvl_a[40] = 64;
    @(negedge clk);
    rdw(5'd6, rd); chk({31'd0, rd[8]}, 0, "R3 upper NE q40");
    rdw(5'd7, rd); chk({31'd0, rd[8]}, 1, "R3 upper F q40");

    uf_pulse[17] = 1; of_pulse[3] = 1;
    @(negedge clk);
    uf_pulse = 0; of_pulse = 0;
    @(negedge clk);
    rdw(5'd5, rd); chk(rd, 32'h4, "R4 underflow q17 sticky");
    rdw(5'd4, rd); chk(rd, 32'h80, "R4 overflow q3");
    wrw(5'd5, 32'h4);
    rdw(5'd5, rd); chk(rd, 0, "R4 clear q17");
    rdw(5'd4, rd); chk(rd, 32'h80, "R4 other bit kept");

    wrw(5'd14, 32'hFFFFFFFF); wrw(5'd15, 32'hFFFFFFFF);
    rdw(5'd14, rd); chk(rd, 0, "R9 pending cleared");
    wrw(5'd8, 32'h0030_0000); wrw(5'd12, 32'h20);
    lvl_a[5] = 64;
    repeat (2) @(negedge clk);
    rdw(5'd14, rd); chk(rd, 32'h20, "R8 full edge q5");
    chk({31'd0, irq}, 1, "R10 irq raised");
    wrw(5'd14, 32'h20);
    repeat (3) @(negedge clk);
    rdw(5'd14, rd); chk(rd, 0, "R9 no re-set while level holds");
    chk({31'd0, irq}, 0, "R10 irq low after clear");

    wrw(5'd8, 32'h0430_0000); wrw(5'd12, 32'h60);
    lvl_a[6] = 1;
    repeat (2) @(negedge clk);
    rdw(5'd14, rd); chk(rd, 32'h40, "R5 inverted empty q6");
    wrw(5'd14, 32'h40);

    wrw(5'd8, 32'h3430_0000);
    lvl_a[7] = 64;
    repeat (2) @(negedge clk);
    rdw(5'd14, rd); chk(rd, 0, "R8 disabled q7 stays clear");

    wrw(5'd13, 32'h2);
    lvl_a[33] = 10;
    repeat (2) @(negedge clk);
    lvl_a[33] = 2;
    repeat (2) @(negedge clk);
    rdw(5'd15, rd); chk(rd, 32'h2, "R8 upper NE edge q33");
    chk({31'd0, irq}, 1, "R10 irq from upper");

    wrw(5'd16, 32'h1);
    rdw(5'd8, rd); chk({31'd0, rd[3]}, 1, "R6 control bit set");
    wrw(5'd8, 32'h0);
    rdw(5'd8, rd); chk(rd, 32'h8, "R6 control bit kept");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule